// File: doc/BRIEF.md
# Dot Clock Divider Search

This block finds PLL settings for a requested pixel clock. The target frequency arrives in kHz with a one-cycle start pulse. The block then walks through every divider value m from 15 down to 1. For each m it tries a plain path with a 3 MHz reference step. When m is odd it also tries a doubled path with a 6 MHz step. For each path it computes the multiplier n = floor(m·T/step) and the achieved frequency floor(step·n/m). It keeps the candidate whose shortfall below the target is smallest. Because of the floors, a candidate never lands above the target.

Every candidate needs two integer divisions. A single serial restoring divider is shared between them, so one candidate takes roughly two divider runs. A search ends with a done flag and the winning multiplier, divider and doubling flag. These stay frozen until software starts a new search. Programming the PLL with the result is the job of surrounding logic.

The controller has seven named states:
- IDLE: the state after reset, waiting for the first start.
- LAUNCH_N: starts the division that yields n.
- WAIT_N: waits for n and checks that n is in range.
- LAUNCH_V: starts the division that yields the achieved frequency.
- WAIT_V: waits for the achieved frequency and offers the candidate to the best-tracker.
- ADVANCE: moves from the plain path to the doubled path, or to the next smaller m.
- DONE: holds the result.

The transitions are:
- IDLE or DONE go to LAUNCH_N on an accepted start.
- LAUNCH_N goes to WAIT_N.
- WAIT_N goes to LAUNCH_V if n is in range, otherwise to ADVANCE.
- LAUNCH_V goes to WAIT_V.
- WAIT_V goes to ADVANCE.
- ADVANCE goes to LAUNCH_N for the next candidate, or to DONE after the last one.

Top module: `dclk_search`

## Requirements
- R1: After reset, done is 0 and best_n, best_m and best_double are all 0.
- R2: A start pulse while idle or done captures target_khz and starts a search. If done was set, it reads 0 in the following cycle.
- R3: When done rises, the outputs give the candidate with the smallest shortfall T − floor(step·n/m). Here step is 3000 when best_double=0 and 6000 when best_double=1, and n = floor(m·T/step).
- R4: A candidate is considered only when its n lies in 9..127 inclusive, and m is in 1..15. A reported best_double of 1 always comes with an odd best_m.
- R5: Candidates are considered in the order m = 15 down to 1, the plain path before the doubled path at each m. A later candidate replaces the held one only when its shortfall is strictly smaller, so the earliest of equal candidates wins.
- R6: If no candidate has n in range, the search ends with best_n = 0, best_m = 0 and best_double = 0.
- R7: Once done is set, it stays set and the three result outputs stay unchanged until the next accepted start.
- R8: A start pulse during a search has no effect: the running search completes with its original target.
- R9: done rises no later than 24·(2·(TW+4)+6) cycles after an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a search |
| target_khz | input | TW | Target pixel clock in kHz, sampled with start |
| best_n | output | 7 | Chosen PLL multiplier |
| best_m | output | 4 | Chosen divider, 0 if none found |
| best_double | output | 1 | 1 when the 6 MHz doubled path was chosen |
| done | output | 1 | Search finished, result valid |

## Verification
On every cycle, the assertions check these properties:
- the range of a reported result (n within bounds, doubling only with odd m);
- the all-zero form of an empty result;
- that done falls after a restart;
- that the result stays frozen while done is held;
- the latency bound, using a cycle counter.

Some behaviours can only be shown by the bench's scenarios, because they depend on division arithmetic across the whole scan. These are:
- that the reported triple is truly the best of the 23 candidates;
- that ties resolve toward the earliest candidate;
- that a start arriving mid-search is ignored.

Random targets are compared against a bench model for this. Directed targets cover exact ties, tiny inputs and large inputs with no valid candidate.

// File: rtl/dclk_pkg.sv
package dclk_pkg;

    localparam int STEP_PLAIN_KHZ  = 3000;
    localparam int STEP_DOUBLE_KHZ = 6000;
    localparam int N_LOW           = 9;
    localparam int N_HIGH          = 127;
    localparam int M_FIRST         = 15;
    localparam int N_W             = 7;
    localparam int M_W             = 4;
    localparam int SHORT_W         = 28;
    localparam logic [SHORT_W-1:0] SHORT_INIT = 28'h0FFFFFFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH_N,
        ST_WAIT_N,
        ST_LAUNCH_V,
        ST_WAIT_V,
        ST_ADVANCE,
        ST_DONE
    } dclk_state_t;

endpackage

// File: rtl/dclk_serial_div.sv
module dclk_serial_div #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] numer,
    input  logic [W-1:0] denom,
    output logic [W-1:0] quot,
    output logic         fin
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  shf_q;
    logic [W-1:0]  den_q;
    logic [CW-1:0] left_q;
    logic          run_q;
    logic [W:0]    trial;
    logic [W:0]    trial_sub;
    logic          fits;

    // one restoring step: bring down the next dividend bit, subtract if possible
    assign trial     = {rem_q, shf_q[W-1]};
    assign trial_sub = trial - {1'b0, den_q};
    assign fits      = (trial >= {1'b0, den_q});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            shf_q  <= '0;
            den_q  <= '0;
            left_q <= '0;
            run_q  <= 1'b0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                rem_q  <= '0;
                shf_q  <= numer;
                den_q  <= denom;
                left_q <= CW'(W);
                run_q  <= 1'b1;
            end else if (run_q) begin
                rem_q  <= fits ? trial_sub[W-1:0] : trial[W-1:0];
                shf_q  <= {shf_q[W-2:0], fits};
                left_q <= left_q - 1'b1;
                if (left_q == CW'(1)) begin
                    run_q <= 1'b0;
                    fin   <= 1'b1;
                end
            end
        end
    end

    assign quot = shf_q;

endmodule

// File: rtl/dclk_best_track.sv
module dclk_best_track
    import dclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               offer,
    input  logic [N_W-1:0]     cand_n,
    input  logic [M_W-1:0]     cand_m,
    input  logic               cand_dbl,
    input  logic [SHORT_W-1:0] cand_short,
    output logic [N_W-1:0]     best_n,
    output logic [M_W-1:0]     best_m,
    output logic               best_dbl
);
    logic [SHORT_W-1:0] best_short;
    logic               better;

    // strictly smaller only: equal shortfalls keep the earlier candidate
    assign better = offer && (cand_short < best_short);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            best_short <= SHORT_INIT;
            best_n     <= '0;
            best_m     <= '0;
            best_dbl   <= 1'b0;
        end else if (clear) begin
            best_short <= SHORT_INIT;
            best_n     <= '0;
            best_m     <= '0;
            best_dbl   <= 1'b0;
        end else if (better) begin
            best_short <= cand_short;
            best_n     <= cand_n;
            best_m     <= cand_m;
            best_dbl   <= cand_dbl;
        end
    end

endmodule

// File: rtl/dclk_search.sv
module dclk_search
    import dclk_pkg::*;
#(
    parameter int TW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] target_khz,
    output logic [6:0]    best_n,
    output logic [3:0]    best_m,
    output logic          best_double,
    output logic          done
);
    localparam int DW = TW + 4;

    dclk_state_t state, nstate;

    logic [TW-1:0]  tgt_q;
    logic [M_W-1:0] m_q;
    logic           dbl_q;
    logic [N_W-1:0] n_q;
    logic           done_q;

    logic           accept;
    logic           div_go;
    logic [DW-1:0]  div_numer;
    logic [DW-1:0]  div_denom;
    logic [DW-1:0]  div_quot;
    logic           div_fin;
    logic [DW-1:0]  step_khz;
    logic           n_ok;
    logic           last_cand;
    logic           offer;
    logic [TW-1:0]  shortfall;
    logic [SHORT_W-1:0] short_ext;

    assign accept    = start && ((state == ST_IDLE) || (state == ST_DONE));
    assign step_khz  = dbl_q ? DW'(STEP_DOUBLE_KHZ) : DW'(STEP_PLAIN_KHZ);
    assign n_ok      = (div_quot >= DW'(N_LOW)) && (div_quot <= DW'(N_HIGH));
    assign last_cand = (dbl_q || !m_q[0]) && (m_q == M_W'(1));
    assign div_go    = (state == ST_LAUNCH_N) || (state == ST_LAUNCH_V);
    assign offer     = (state == ST_WAIT_V) && div_fin;
    assign shortfall = tgt_q - div_quot[TW-1:0];
    assign short_ext = SHORT_W'(shortfall);

    always_comb begin
        if (state == ST_LAUNCH_N) begin
            div_numer = DW'(m_q) * DW'(tgt_q);
            div_denom = step_khz;
        end else begin
            div_numer = step_khz * DW'(n_q);
            div_denom = DW'(m_q);
        end
    end

    dclk_serial_div #(.W(DW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .numer (div_numer),
        .denom (div_denom),
        .quot  (div_quot),
        .fin   (div_fin)
    );

    dclk_best_track u_best (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .offer      (offer),
        .cand_n     (n_q),
        .cand_m     (m_q),
        .cand_dbl   (dbl_q),
        .cand_short (short_ext),
        .best_n     (best_n),
        .best_m     (best_m),
        .best_dbl   (best_double)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // transitions
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:     if (accept) nstate = ST_LAUNCH_N;
            ST_LAUNCH_N: nstate = ST_WAIT_N;
            ST_WAIT_N:   if (div_fin) nstate = n_ok ? ST_LAUNCH_V : ST_ADVANCE;
            ST_LAUNCH_V: nstate = ST_WAIT_V;
            ST_WAIT_V:   if (div_fin) nstate = ST_ADVANCE;
            ST_ADVANCE:  nstate = last_cand ? ST_DONE : ST_LAUNCH_N;
            ST_DONE:     if (accept) nstate = ST_LAUNCH_N;
            default:     nstate = ST_IDLE;
        endcase
    end

    // scan registers and done flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q  <= '0;
            m_q    <= '0;
            dbl_q  <= 1'b0;
            n_q    <= '0;
            done_q <= 1'b0;
        end else begin
            if (accept) begin
                tgt_q  <= target_khz;
                m_q    <= M_W'(M_FIRST);
                dbl_q  <= 1'b0;
                done_q <= 1'b0;
            end
            if ((state == ST_WAIT_N) && div_fin)
                n_q <= div_quot[N_W-1:0];
            if (state == ST_ADVANCE) begin
                if (last_cand) begin
                    done_q <= 1'b1;
                end else if (!dbl_q && m_q[0]) begin
                    dbl_q <= 1'b1;
                end else begin
                    dbl_q <= 1'b0;
                    m_q   <= m_q - 1'b1;
                end
            end
        end
    end

    assign done = done_q;

endmodule

// File: rtl/dclk_search_chk.sv
module dclk_search_chk #(
    parameter int TW = 20
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [6:0] best_n,
    input logic [3:0] best_m,
    input logic       best_double,
    input logic       done
);
    localparam int LIMIT = 24 * (2 * (TW + 4) + 6);

    logic        busy_q;
    logic [15:0] lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            lat_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                lat_q  <= '0;
            end
        end else if (done) begin
            busy_q <= 1'b0;
        end else begin
            lat_q <= lat_q + 1'b1;
        end
    end

    AST_RESTART_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && done) |=> !done); // R2
    AST_N_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && best_m != 4'd0) |-> (best_n >= 7'd9 && best_n <= 7'd127)); // R4
    AST_DOUBLE_ODD_M: assert property (@(posedge clk) disable iff (!rst_n)
        (done && best_double) |-> best_m[0]); // R4
    AST_EMPTY_ALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && best_m == 4'd0) |-> (best_n == 7'd0 && !best_double)); // R6
    AST_RESULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(best_n) && $stable(best_m) && $stable(best_double))); // R7
    AST_LATENCY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (lat_q <= 16'(LIMIT))); // R9

endmodule

bind dclk_search dclk_search_chk #(.TW(TW)) u_chk (.*);

// File: tb/test_dclk_search.sv
module test_dclk_search;
    localparam int TW    = 20;
    localparam int LIMIT = 24 * (2 * (TW + 4) + 6);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [TW-1:0] target_khz = '0;
    logic [6:0]    best_n;
    logic [3:0]    best_m;
    logic          best_double;
    logic          done;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    dclk_search #(.TW(TW)) i_dclk_search (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .target_khz  (target_khz),
        .best_n      (best_n),
        .best_m      (best_m),
        .best_double (best_double),
        .done        (done)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // bench model of the scan
    function automatic void model(input longint t, output int en, output int em, output int ed);
        longint best = 64'h0FFFFFFF;
        en = 0; em = 0; ed = 0;
        for (int m = 15; m >= 1; m--) begin
            for (int d = 0; d < 2; d++) begin
                longint step = (d == 1) ? 6000 : 3000;
                longint n;
                if (d == 1 && (m % 2) == 0) continue;
                n = (m * t) / step;
                if (n >= 9 && n <= 127) begin
                    longint diff = t - (step * n) / m;
                    if (diff < best) begin
                        best = diff; en = int'(n); em = m; ed = d;
                    end
                end
            end
        end
    endfunction

    task automatic pulse_start(input longint t);
        @(negedge clk);
        start = 1'b1;
        target_khz = TW'(t);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int cycles);
        cycles = 1;
        while (!done && cycles < LIMIT + 50) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic run_one(input longint t, input string req);
        int en, em, ed, cyc;
        model(t, en, em, ed);
        pulse_start(t);
        wait_done(cyc);
        check({req, " done"}, done, 1);
        check({req, " n"}, best_n, en);
        check({req, " m"}, best_m, em);
        check({req, " double"}, best_double, ed);
    endtask

    initial begin
        int cyc;
        int en, em, ed;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 done", done, 0);
        check("R1 n", best_n, 0);
        check("R1 m", best_m, 0);
        check("R1 double", best_double, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: latency from an accepted start
        pulse_start(25175);
        wait_done(cyc);
        check("R9 within bound", (cyc <= LIMIT) ? 1 : 0, 1);
        model(25175, en, em, ed);
        check("R3 n 25175", best_n, en);
        check("R3 m 25175", best_m, em);

        // R7: result held
        repeat (40) @(negedge clk);
        check("R7 done held", done, 1);
        check("R7 n held", best_n, en);
        check("R7 m held", best_m, em);

        // R2: done drops the cycle after restart
        @(negedge clk);
        start = 1'b1;
        target_khz = TW'(148500);
        @(negedge clk);
        start = 1'b0;
        check("R2 done cleared", done, 0);
        wait_done(cyc);
        model(148500, en, em, ed);
        check("R2 n new target", best_n, en);
        check("R2 m new target", best_m, em);

        // R5: exact tie, m=15 doubled gives n=75 first
        run_one(30000, "R5 tie");
        check("R5 tie winner m", best_m, 15);
        check("R5 tie winner double", best_double, 1);
        check("R5 tie winner n", best_n, 75);

        // R6: nothing in range
        run_one(1000, "R6 small");
        check("R6 small m zero", best_m, 0);
        run_one(0, "R6 zero");
        run_one(1048575, "R6 large");
        check("R6 large m zero", best_m, 0);

        // R4: boundary targets around the n limits
        run_one(2000, "R4 low edge");
        run_one(381000, "R4 high edge");
        run_one(767999, "R4 doubled only");

        // R8: start during a search is ignored
        model(30000, en, em, ed);
        pulse_start(30000);
        repeat (50) @(negedge clk);
        start = 1'b1;
        target_khz = TW'(100000);
        @(negedge clk);
        start = 1'b0;
        wait_done(cyc);
        check("R8 n", best_n, en);
        check("R8 m", best_m, em);
        check("R8 double", best_double, ed);

        // R3: random targets
        for (int i = 0; i < 30; i++) begin
            longint t = longint'($urandom_range(5000, 800000));
            run_one(t, "R3 random");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1600000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule